// File: doc/BRIEF.md
# Multi-timer preload update controller

This block decides when the shadow values of six timers are moved into their live registers. Timer 0 is the master and timer 1 is the leader of a second group. Timers 2 to 5 are followers. Each timer holds a preload compare value, a preload period value, a configuration word and a repetition counter, all written over a simple write-only register bus. The live compare and period values of every timer are driven out as flat buses for the output stages, which are outside this block.

A timer moves its preload values into its live registers on a gated update strobe. That strobe is the OR of the sources the timer has enabled: the expiry of its own repetition counter, the master's update strobe, or timer 1's update strobe. Chained strobes pass through in the same clock. One shared disable word holds one freeze bit per timer. Software sets the bits, rewrites the preloads at leisure, then clears them. The new values go live at the next selected event. Because all the bits sit in one word, timers that run out of step with each other are frozen and released together. The repetition counters count the period-rollover pulses that come from the timer counters.

Top module: `tmr_update_ctl`

## Requirements
- R1: A bus write with `wr_addr[4:2]`=7 and `wr_addr[1:0]`=0 loads the shared disable word from `wr_data[5:0]`, where bit i freezes timer i. A single write sets or clears any combination. Reset clears the word.
- R2: While the disable bit of timer i is set, `upd_o[i]` stays low and no update event changes that timer's live compare or period value.
- R3: Clearing a disable bit causes no transfer by itself. The copy happens at the next selected update event of that timer.
- R4: Each timer's repetition counter resets to 0. On each `roll_i[i]` pulse it reloads from its configured value if it is 0, and otherwise decrements. `rep_o[i]` is high in the cycle where `roll_i[i]` is high and the count is 0, so a reload value of N gives one event every N+1 rollovers.
- R5: Configuration word bit 9 (register `wr_addr[1:0]`=2, bits 7:0 being the reload value) makes a timer update on its own repetition event.
- R6: Configuration bit 10 makes timers 1 to 5 raise `upd_o[i]` in the same cycle as the master's gated strobe `upd_o[0]`. A frozen master therefore also holds its followers.
- R7: Configuration bit 11 makes timers 2 to 5 raise `upd_o[i]` in the same cycle as timer 1's gated strobe `upd_o[1]`.
- R8: All enabled sources of a timer are OR-combined. Any one of them triggers the update unless the timer is frozen.
- R9: In the cycle `upd_o[i]` is high, both preload values of timer i (compare at register 0, period at register 1) are copied together. They are visible on `act_cmp_o` and `act_per_o` after that clock edge. Preload writes alone leave the live values unchanged.
- R10: When configuration bit 8 (bypass) is set, a compare or period write also goes to the live register and is visible after the write clock.
- R11: After reset, all live values, strobes and repetition events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 5 | Timer index [4:2], register [1:0] |
| wr_data | input | 16 | Write data |
| roll_i | input | 6 | Period rollover pulse per timer |
| upd_o | output | 6 | Gated update strobe per timer |
| rep_o | output | 6 | Repetition event per timer |
| act_cmp_o | output | 96 | Live compare values, timer i at [16i+15:16i] |
| act_per_o | output | 96 | Live period values, timer i at [16i+15:16i] |

## Verification
A wrong repetition count first shows as `upd_o` and `rep_o` pulsing on the wrong rollover. That error is visible in the same cycle as the rollover and repeats every period. A wrong disable or source state shows as a follower that misses or gains a strobe beside its leader. It also shows as a live value that changes, or fails to change, one clock after that leader's event. A stale or torn preload copy appears on the live buses right after the next strobe, where compare and period values would disagree with what was written.

// File: rtl/tmr_update_ctl.sv
module tmr_update_ctl #(
  parameter int NT = 6,
  parameter int DW = 16,
  parameter int RW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NT-1:0]    roll_i,
  output logic [NT-1:0]    upd_o,
  output logic [NT-1:0]    rep_o,
  output logic [NT*DW-1:0] act_cmp_o,
  output logic [NT*DW-1:0] act_per_o
);
  localparam int BYP = RW;
  localparam int OWN = RW + 1;
  localparam int FLM = RW + 2;
  localparam int FLA = RW + 3;
  localparam int CW  = RW + 4;

  logic [NT-1:0][DW-1:0] pre_cmp, pre_per, act_cmp, act_per;
  logic [NT-1:0][CW-1:0] cfg;
  logic [NT-1:0][RW-1:0] rep_cnt;
  logic [NT-1:0]         dis_q, src;
  logic                  upd_m, upd_a, dis_wr;

  assign dis_wr = wr_en && wr_addr == 5'b11100;
  assign upd_m  = cfg[0][OWN] && rep_o[0] && !dis_q[0];
  assign upd_a  = ((cfg[1][OWN] && rep_o[1]) || (cfg[1][FLM] && upd_m)) && !dis_q[1];
  assign upd_o  = src & ~dis_q;
  assign act_cmp_o = act_cmp;
  assign act_per_o = act_per;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dis_q <= '0;
    else if (dis_wr) dis_q <= wr_data[NT-1:0];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic hit;
    assign hit      = wr_en && wr_addr[4:2] == 3'(i);
    assign rep_o[i] = roll_i[i] && rep_cnt[i] == '0;

    if (i == 0) begin : g_m
      assign src[i] = cfg[i][OWN] && rep_o[i];
    end else if (i == 1) begin : g_a
      assign src[i] = (cfg[i][OWN] && rep_o[i]) || (cfg[i][FLM] && upd_m);
    end else begin : g_s
      assign src[i] = (cfg[i][OWN] && rep_o[i]) || (cfg[i][FLM] && upd_m)
                   || (cfg[i][FLA] && upd_a);
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pre_cmp[i] <= '0;
        pre_per[i] <= '0;
        act_cmp[i] <= '0;
        act_per[i] <= '0;
        cfg[i]     <= '0;
        rep_cnt[i] <= '0;
      end else begin
        if (roll_i[i])
          rep_cnt[i] <= (rep_cnt[i] == '0) ? cfg[i][RW-1:0] : rep_cnt[i] - 1'b1;
        if (hit && wr_addr[1:0] == 2'd2) cfg[i] <= wr_data[CW-1:0];
        if (hit && wr_addr[1:0] == 2'd0) pre_cmp[i] <= wr_data;
        if (hit && wr_addr[1:0] == 2'd1) pre_per[i] <= wr_data;
        if (upd_o[i]) begin
          act_cmp[i] <= pre_cmp[i];
          act_per[i] <= pre_per[i];
        end
        if (hit && cfg[i][BYP] && wr_addr[1:0] == 2'd0) act_cmp[i] <= wr_data;
        if (hit && cfg[i][BYP] && wr_addr[1:0] == 2'd1) act_per[i] <= wr_data;
      end
  end
endmodule

// File: rtl/tmr_update_ctl_chk.sv
module tmr_update_ctl_chk #(
  parameter int NT = 6,
  parameter int DW = 16,
  parameter int RW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [4:0]            wr_addr,
  input logic [NT-1:0]         roll_i,
  input logic [NT-1:0]         upd_o,
  input logic [NT-1:0]         rep_o,
  input logic [NT-1:0]         dis_q,
  input logic                  upd_m,
  input logic [NT-1:0][RW+3:0] cfg,
  input logic [NT-1:0][DW-1:0] pre_cmp,
  input logic [NT-1:0][DW-1:0] act_cmp
);
  for (genvar i = 0; i < NT; i++) begin : g_p
    logic hit;
    assign hit = wr_en && wr_addr[4:2] == 3'(i);

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[i] |-> !upd_o[i]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q[i] && !hit) |=> $stable(act_cmp[i]));
    p_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o[i] && !hit) |=> act_cmp[i] == $past(pre_cmp[i]));
    p_rep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rep_o[i] |-> roll_i[i]);
    if (i > 0) begin : g_f
      p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[i][RW+2] && upd_m && !dis_q[i]) |-> upd_o[i]);
    end
  end
endmodule

bind tmr_update_ctl tmr_update_ctl_chk #(.NT(NT), .DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .roll_i(roll_i),
  .upd_o(upd_o), .rep_o(rep_o), .dis_q(dis_q), .upd_m(upd_m), .cfg(cfg),
  .pre_cmp(pre_cmp), .act_cmp(act_cmp)
);

// File: tb/tmr_update_ctl_tb.sv
module tmr_update_ctl_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  roll_i = '0, upd_o, rep_o, cu, cr;
  logic [95:0] act_cmp_o, act_per_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_update_ctl u_dut (.*);

  // {roll, expected upd, expected rep}
  localparam logic [17:0] VEC [7] = '{
    {6'h01, 6'h0D, 6'h01}, {6'h01, 6'h00, 6'h00}, {6'h02, 6'h32, 6'h02},
    {6'h03, 6'h3F, 6'h03}, {6'h04, 6'h00, 6'h04}, {6'h01, 6'h00, 6'h00},
    {6'h01, 6'h0D, 6'h01}};

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", r, got, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [4:0] a, input logic [15:0] d, input logic [5:0] r);
    wr_en = we; wr_addr = a; wr_data = d; roll_i = r;
    #1 cu = upd_o; cr = rep_o;
    @(negedge clk);
    wr_en = 0; roll_i = '0;
  endtask

  function automatic logic [15:0] cmp(input int i); return act_cmp_o[i*16 +: 16]; endfunction
  function automatic logic [15:0] per(input int i); return act_per_o[i*16 +: 16]; endfunction
  function automatic logic [4:0] ad(input int t, input int r); return 5'(t*4 + r); endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 live cmp", act_cmp_o[31:0], 0);
    chk("R11 strobes", {upd_o, rep_o}, 0);
    rst_n = 1;
    @(negedge clk);
    cyc(1, ad(0,2), 16'h0201, 0);
    cyc(1, ad(1,2), 16'h0200, 0);
    cyc(1, ad(2,2), 16'h0400, 0);
    cyc(1, ad(3,2), 16'h0400, 0);
    cyc(1, ad(4,2), 16'h0800, 0);
    cyc(1, ad(5,2), 16'h0800, 0);
    for (int v = 0; v < 7; v++) begin
      cyc(0, 0, 0, VEC[v][17:12]);
      chk("R5 R6 R7 R8 upd vector", cu, VEC[v][11:6]);
      chk("R4 rep vector", cr, VEC[v][5:0]);
    end
    // R9: preload writes stay hidden until the event
    cyc(1, ad(0,0), 16'h1111, 0);
    cyc(1, ad(2,0), 16'h2222, 0);
    cyc(1, ad(4,1), 16'h3333, 0);
    chk("R9 preload hidden", cmp(0), 0);
    cyc(0, 0, 0, 6'h01);
    chk("R9 no event yet", cmp(0), 0);
    cyc(0, 0, 0, 6'h01);
    chk("R9 master copy", cmp(0), 16'h1111);
    chk("R6 follower copy", cmp(2), 16'h2222);
    chk("R7 D not yet", per(4), 0);
    cyc(0, 0, 0, 6'h02);
    chk("R7 D copy via timer 1", per(4), 16'h3333);
    // R1/R2: freeze master and timer 2 together
    cyc(1, ad(7,0), 16'h0005, 0);
    cyc(1, ad(0,0), 16'h4444, 0);
    cyc(1, ad(2,0), 16'h5555, 0);
    cyc(1, ad(3,0), 16'h6666, 0);
    cyc(0, 0, 0, 6'h01);
    cyc(0, 0, 0, 6'h01);
    chk("R2 frozen no strobe", cu, 0);
    chk("R2 master held", cmp(0), 16'h1111);
    chk("R2 follower C held by frozen master", cmp(3), 0);
    cyc(1, ad(7,0), 16'h0000, 0);
    chk("R3 clear causes no copy", cmp(0), 16'h1111);
    cyc(0, 0, 0, 6'h01);
    chk("R3 no event", cmp(2), 16'h2222);
    cyc(0, 0, 0, 6'h01);
    chk("R3 master after release", cmp(0), 16'h4444);
    chk("R3 B after release", cmp(2), 16'h5555);
    chk("R3 C after release", cmp(3), 16'h6666);
    // R1: freeze only timer 2
    cyc(1, ad(7,0), 16'h0004, 0);
    cyc(1, ad(0,0), 16'h7777, 0);
    cyc(1, ad(2,0), 16'h8888, 0);
    cyc(0, 0, 0, 6'h01);
    cyc(0, 0, 0, 6'h01);
    chk("R1 partial freeze strobes", cu, 6'h09);
    chk("R1 master updated", cmp(0), 16'h7777);
    chk("R1 B frozen", cmp(2), 16'h5555);
    // R10: bypass
    cyc(1, ad(5,2), 16'h0900, 0);
    cyc(1, ad(5,0), 16'hABCD, 0);
    chk("R10 bypass cmp", cmp(5), 16'hABCD);
    cyc(1, ad(5,1), 16'h1234, 0);
    chk("R10 bypass per", per(5), 16'h1234);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule